// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the memory-side engine of a 16-bit synchronous burst read port. A host raises an address-valid strobe while chip enable is high. The sequencer captures the start word address on that clock edge and waits a programmed number of clocks. It then puts consecutive words from an internal synchronous RAM on the data bus. An active-high WAIT output flags every cycle of a burst that carries no valid word. It covers the initial latency, the stalls between four-word groups, and the cycles just before or after them when early WAIT timing is chosen.

A 10-bit configuration word, written through a direct parallel port, selects the behaviour. The fields are:

- bit 0: page-mode select.
- bits 3:1: latency code.
- bit 4: two-clock data hold.
- bit 5: early WAIT.
- bit 6: linear (no-wrap) addressing.
- bits 9:7: burst length code.

The reset value is 0x3C9. This selects page mode, latency 4, no hold, normal WAIT, linear addressing and a continuous burst. The array is loaded through a separate write port. The configuration is captured when a burst starts, so later writes do not disturb a burst in flight.

Top module: `brs_burst_seq`

## Requirements
- R1: While bit 0 of the configuration is 1 (reset default), no burst starts. `dq_drive` and `wait_o` stay 0 and `dq_out` is 0.
- R2: The edge that samples `ce`=1 and `adv`=1 in burst mode is edge 0. The first word appears after edge L, where L is the latency code in bits 3:1. With normal WAIT timing, `wait_o` is 1 after edges 0 to L-1.
- R3: With hold off, latency codes 5, 6 and 7 insert 1, 2 and 3 WAIT cycles after every fourth word of the burst, counted from its first word. Codes 2 to 4 insert none. No stall follows the final word of a fixed burst.
- R4: With hold on (bit 4 = 1), each word stays on the bus for two clocks and no group stalls are inserted.
- R5: Length code (bits 9:7) 001, 010 and 011 give bursts of 4, 8 and 16 words, after which `dq_drive` and `wait_o` return to 0. Code 111 gives a continuous burst.
- R6: With bit 6 = 0 and a fixed length N, word k is read from address (A with its low log2(N) bits cleared) OR ((A+k) mod N). With bit 6 = 1, or with a continuous burst, it is read from (A+k) mod 2^AW.
- R7: With early WAIT (bit 5 = 1), `wait_o` at a burst cycle equals "no valid word" of the cycle one clock later, or two clocks later when hold is on. It is 0 when that later cycle is past the end of the burst.
- R8: `config_error` is 1 exactly when one of these holds: the length code is reserved, the latency code is 0 or 1, or hold is on together with latency 2 and early WAIT. A strobe under such a configuration starts nothing, and `dq_drive` and `wait_o` are 0 on the next cycle.
- R9: When `ce` is low at an edge, `dq_drive` and `wait_o` are 0 after that edge.
- R10: A new strobe during a burst abandons it and starts a fresh burst at the new address, with full latency.
- R11: While `dq_drive` is 1, `dq_out` equals the array word last written at the address given by R6. Otherwise `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word |
| mem_we | input | 1 | Array write strobe |
| mem_waddr | input | AW | Array write address |
| mem_wdata | input | DW | Array write data |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address-valid strobe, active high |
| start_addr | input | AW | Burst start word address |
| dq_out | output | DW | Burst data bus |
| dq_drive | output | 1 | High while `dq_out` carries a valid word |
| wait_o | output | 1 | WAIT, active high |
| config_error | output | 1 | Unsupported configuration flag |

## Verification
The bench sweeps every legal combination of latency code (2 to 7), length code, wrap bit, hold bit and WAIT timing. Each burst starts from a shifting address, so bursts begin at block starts, mid-block and near the top of the array. Each clock's data, drive and WAIT is compared with an arithmetic slot model. Latency codes 2 to 4 against 5 to 7 show whether group stalls are present and sized right. Hold on and off show whether words are doubled and stalls suppressed. The wrap bit against continuous length shows whether addresses fold back inside the block. Separate runs cover page mode, each error cause, a restart strobe mid-burst and a chip-enable drop.

// File: rtl/brs_pkg.sv
package brs_pkg;

    // Slot kinds produced by the generator, one per clock of a burst
    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_LAT   = 2'd1,
        GEN_DATA  = 2'd2,
        GEN_STALL = 2'd3
    } gen_mode_e;

    // Configuration word layout, MSB first
    typedef struct packed {
        logic [2:0] len_code;
        logic       linear;
        logic       wait_early;
        logic       hold2;
        logic [2:0] lat_code;
        logic       async_mode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam int IDX_W = 4;

    localparam cfg_t CFG_RESET = '{
        len_code:   3'b111,
        linear:     1'b1,
        wait_early: 1'b0,
        hold2:      1'b0,
        lat_code:   3'd4,
        async_mode: 1'b1
    };

    // True when the length code is not one of the four defined codes
    function automatic logic len_reserved(input logic [2:0] code);
        return !(code == 3'b001 || code == 3'b010 ||
                 code == 3'b011 || code == 3'b111);
    endfunction

    // Index of the last word of a fixed burst
    function automatic logic [IDX_W-1:0] len_last(input logic [2:0] code);
        case (code)
            3'b001:  return IDX_W'(3);
            3'b010:  return IDX_W'(7);
            default: return IDX_W'(15);
        endcase
    endfunction

    // Stall cycles after each four-word group
    function automatic logic [2:0] stall_count(input logic [2:0] lat, input logic hold);
        if (hold || lat <= 3'd4) return 3'd0;
        return lat - 3'd4;
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
// Configuration register with legality decode.
// Assumes writes arrive as whole words; the error flag is a pure decode of
// the stored word, so it follows a write by one clock.
module brs_cfg_reg (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [brs_pkg::CFG_W-1:0]  wdata,
    output brs_pkg::cfg_t              cfg_q,
    output logic                       err
);
    import brs_pkg::*;

    // Holds the configuration word; reset selects page mode
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= CFG_RESET;
        else if (we) cfg_q <= cfg_t'(wdata);
    end

    // Flags reserved lengths, too-short latency and the unsupported hold combination
    always_comb begin
        err = len_reserved(cfg_q.len_code)
            || (cfg_q.lat_code < 3'd2)
            || (cfg_q.hold2 && cfg_q.lat_code == 3'd2 && cfg_q.wait_early);
    end

endmodule

// File: rtl/brs_word_ram.sv
// Simple synchronous RAM: one write port, one read port with a registered
// output. Assumes the read address is valid one clock before the data is used.
module brs_word_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Stores a word on a write strobe
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registers the addressed word
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/brs_slot_gen.sv
// Slot generator: walks the burst schedule one clock per step. It produces
// latency, data or stall slots and tracks the word address with wrap.
// It runs two slots ahead of the bus. The start step applies the schedule
// once to the state of slot 1, so the register holds slot 2 after the
// address edge. Assumes start and abort are never high together.
module brs_slot_gen #(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  brs_pkg::cfg_t     cfg,
    input  logic [AW-1:0]     start_addr,
    output logic              slot_act,
    output logic              slot_data,
    output logic [AW-1:0]     slot_addr,
    output logic              hold_o,
    output logic              early_o
);
    import brs_pkg::*;

    localparam int IW = IDX_W;

    gen_mode_e     mode_q, mode_d, c_mode;
    logic [2:0]    lat_q, lat_d, c_lat;
    logic [2:0]    stl_q, stl_d, c_stl;
    logic [1:0]    grp_q, grp_d, c_grp;
    logic          half_q, half_d, c_half;
    logic [IW-1:0] idx_q, idx_d, c_idx;
    logic [AW-1:0] addr_q, addr_d, c_addr;

    logic [IW-1:0] last_q, e_last;
    logic          fixed_q, e_fixed;
    logic          wrap_q, e_wrap;
    logic          hold_q, e_hold;
    logic          early_q;
    logic [2:0]    stall_q, e_stall;

    logic [AW-1:0] mask, inc, nxt_addr;

    // Selects the current state: a start replaces it with the slot-1 state
    always_comb begin
        if (start) begin
            e_last  = len_last(cfg.len_code);
            e_fixed = (cfg.len_code != 3'b111);
            e_wrap  = (cfg.len_code != 3'b111) && !cfg.linear;
            e_hold  = cfg.hold2;
            e_stall = stall_count(cfg.lat_code, cfg.hold2);
            c_mode  = GEN_LAT;
            c_lat   = cfg.lat_code - 3'd2;
            c_stl   = 3'd0;
            c_grp   = 2'd0;
            c_half  = 1'b0;
            c_idx   = '0;
            c_addr  = start_addr;
        end else begin
            e_last  = last_q;
            e_fixed = fixed_q;
            e_wrap  = wrap_q;
            e_hold  = hold_q;
            e_stall = stall_q;
            c_mode  = mode_q;
            c_lat   = lat_q;
            c_stl   = stl_q;
            c_grp   = grp_q;
            c_half  = half_q;
            c_idx   = idx_q;
            c_addr  = addr_q;
        end
    end

    // Next word address, folded inside the aligned block when wrapping
    always_comb begin
        mask     = AW'(e_last);
        inc      = c_addr + AW'(1);
        nxt_addr = e_wrap ? ((c_addr & ~mask) | (inc & mask)) : inc;
    end

    // One schedule step from the current slot to the next
    always_comb begin
        mode_d = c_mode;
        lat_d  = c_lat;
        stl_d  = c_stl;
        grp_d  = c_grp;
        half_d = c_half;
        idx_d  = c_idx;
        addr_d = c_addr;
        case (c_mode)
            GEN_LAT: begin
                if (c_lat == 3'd0) begin
                    mode_d = GEN_DATA;
                    idx_d  = '0;
                    grp_d  = 2'd0;
                    half_d = 1'b0;
                end else begin
                    lat_d = c_lat - 3'd1;
                end
            end
            GEN_DATA: begin
                if (e_hold && !c_half) begin
                    half_d = 1'b1;
                end else if (e_fixed && c_idx == e_last) begin
                    mode_d = GEN_IDLE;
                end else if (c_grp == 2'd3 && e_stall != 3'd0) begin
                    mode_d = GEN_STALL;
                    stl_d  = e_stall - 3'd1;
                end else begin
                    idx_d  = c_idx + IW'(1);
                    grp_d  = c_grp + 2'd1;
                    half_d = 1'b0;
                    addr_d = nxt_addr;
                end
            end
            GEN_STALL: begin
                if (c_stl == 3'd0) begin
                    mode_d = GEN_DATA;
                    idx_d  = c_idx + IW'(1);
                    grp_d  = c_grp + 2'd1;
                    half_d = 1'b0;
                    addr_d = nxt_addr;
                end else begin
                    stl_d = c_stl - 3'd1;
                end
            end
            default: mode_d = GEN_IDLE;
        endcase
        if (abort) mode_d = GEN_IDLE;
    end

    // Advances the schedule state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= GEN_IDLE;
            lat_q  <= 3'd0;
            stl_q  <= 3'd0;
            grp_q  <= 2'd0;
            half_q <= 1'b0;
            idx_q  <= '0;
            addr_q <= '0;
        end else begin
            mode_q <= mode_d;
            lat_q  <= lat_d;
            stl_q  <= stl_d;
            grp_q  <= grp_d;
            half_q <= half_d;
            idx_q  <= idx_d;
            addr_q <= addr_d;
        end
    end

    // Captures the burst configuration at the address edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            fixed_q <= 1'b0;
            wrap_q  <= 1'b0;
            hold_q  <= 1'b0;
            early_q <= 1'b0;
            stall_q <= 3'd0;
        end else if (start) begin
            last_q  <= e_last;
            fixed_q <= e_fixed;
            wrap_q  <= e_wrap;
            hold_q  <= e_hold;
            early_q <= cfg.wait_early;
            stall_q <= e_stall;
        end
    end

    assign slot_act  = (mode_q != GEN_IDLE);
    assign slot_data = (mode_q == GEN_DATA);
    assign slot_addr = addr_q;
    assign hold_o    = hold_q;
    assign early_o   = early_q;

endmodule

// File: rtl/brs_burst_seq.sv
// Burst read sequencer top. The generator runs two slots ahead. A two-stage
// slot pipeline brings its output to the bus, and the first stage addresses
// the RAM so the registered RAM word lines up with the second stage. WAIT
// looks at stage 2, stage 1 or the generator output, depending on how early
// it must change. Assumes ce, adv and start_addr are synchronous to clk.
module brs_burst_seq #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [brs_pkg::CFG_W-1:0] cfg_wdata,
    input  logic                      mem_we,
    input  logic [AW-1:0]             mem_waddr,
    input  logic [DW-1:0]             mem_wdata,
    input  logic                      ce,
    input  logic                      adv,
    input  logic [AW-1:0]             start_addr,
    output logic [DW-1:0]             dq_out,
    output logic                      dq_drive,
    output logic                      wait_o,
    output logic                      config_error
);
    import brs_pkg::*;

    cfg_t          cfg;
    logic          cfg_err;
    logic          go, kill;
    logic          g_act, g_data, g_hold, g_early;
    logic [AW-1:0] g_addr;
    logic          p1_act, p1_data, p2_act, p2_data;
    logic [AW-1:0] p1_addr;
    logic [DW-1:0] ram_q;
    logic          lead_act, lead_data;

    brs_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg),
        .err   (cfg_err)
    );

    // Decides between starting a burst and flushing the current one
    always_comb begin
        go   = ce && adv && !cfg.async_mode && !cfg_err;
        kill = !ce || cfg.async_mode || (adv && cfg_err);
    end

    brs_slot_gen #(.AW(AW)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go),
        .abort      (kill),
        .cfg        (cfg),
        .start_addr (start_addr),
        .slot_act   (g_act),
        .slot_data  (g_data),
        .slot_addr  (g_addr),
        .hold_o     (g_hold),
        .early_o    (g_early)
    );

    // Carries slots from the generator to the bus; a start loads two latency slots
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            p1_act  <= 1'b0;
            p1_data <= 1'b0;
            p1_addr <= '0;
            p2_act  <= 1'b0;
            p2_data <= 1'b0;
        end else if (go) begin
            p1_act  <= 1'b1;
            p1_data <= 1'b0;
            p1_addr <= start_addr;
            p2_act  <= 1'b1;
            p2_data <= 1'b0;
        end else begin
            p1_act  <= g_act;
            p1_data <= g_data;
            p1_addr <= g_addr;
            p2_act  <= p1_act;
            p2_data <= p1_data;
        end
    end

    brs_word_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (p1_addr),
        .rdata (ram_q)
    );

    // Picks the slot that WAIT reports: now, one clock ahead or two ahead
    always_comb begin
        if (!g_early) begin
            lead_act  = p2_act;
            lead_data = p2_data;
        end else if (g_hold) begin
            lead_act  = g_act;
            lead_data = g_data;
        end else begin
            lead_act  = p1_act;
            lead_data = p1_data;
        end
    end

    // Drives the bus outputs
    always_comb begin
        dq_drive     = p2_act && p2_data;
        dq_out       = dq_drive ? ram_q : '0;
        wait_o       = p2_act && lead_act && !lead_data;
        config_error = cfg_err;
    end

endmodule

// File: rtl/brs_burst_seq_chk.sv
// Port-level checker for brs_burst_seq. It keeps its own copy of the
// page-mode bit from the configuration writes it observes.
module brs_burst_seq_chk (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [brs_pkg::CFG_W-1:0] cfg_wdata,
    input logic                      ce,
    input logic                      adv,
    input logic                      dq_drive,
    input logic                      wait_o,
    input logic                      config_error
);
    logic async_seen;

    // Tracks the page-mode bit as written
    always_ff @(posedge clk) begin
        if (!rst_n)      async_seen <= 1'b1;
        else if (cfg_we) async_seen <= cfg_wdata[0];
    end

    // R1
    async_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_seen |=> !dq_drive);

    // R2
    lead_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && adv && !async_seen && !config_error) |=> (wait_o && !dq_drive));

    // R8
    err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && adv && config_error) |=> (!dq_drive && !wait_o));

    // R8
    err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(config_error));

    // R9
    ce_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> (!dq_drive && !wait_o));

endmodule

bind brs_burst_seq brs_burst_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .ce           (ce),
    .adv          (adv),
    .dq_drive     (dq_drive),
    .wait_o       (wait_o),
    .config_error (config_error)
);

// File: tb/brs_burst_seq_tb_top.sv
`timescale 1ns/1ps
module brs_burst_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_waddr = '0;
    logic [15:0] mem_wdata = '0;
    logic        ce = 1'b0;
    logic        adv = 1'b0;
    logic [7:0]  start_addr = '0;
    logic [15:0] dq_out;
    logic        dq_drive;
    logic        wait_o;
    logic        config_error;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    // Burst parameters used by the reference model
    int t_lc, t_len, t_lin, t_hold, t_early, t_base;

    always #4 clk = ~clk;

    brs_burst_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .ce           (ce),
        .adv          (adv),
        .start_addr   (start_addr),
        .dq_out       (dq_out),
        .dq_drive     (dq_drive),
        .wait_o       (wait_o),
        .config_error (config_error)
    );

    function automatic logic [15:0] pat(input logic [7:0] a);
        return {a ^ 8'hA5, ~a};
    endfunction

    // Reference slot s after the address edge: {active, data, address}
    function automatic logic [9:0] ref_slot(input int s);
        int j, n, st, p, g, pos, a;
        if (s < t_lc) return {1'b1, 1'b0, 8'h00};
        j = s - t_lc;
        if (t_hold != 0) begin
            n = j / 2;
        end else begin
            st  = (t_lc > 4) ? t_lc - 4 : 0;
            p   = 4 + st;
            g   = j / p;
            pos = j % p;
            if (pos >= 4) begin
                if (t_len != 0 && 4 * g + 4 >= t_len) return 10'h000;
                return {1'b1, 1'b0, 8'h00};
            end
            n = 4 * g + pos;
        end
        if (t_len != 0 && n >= t_len) return 10'h000;
        if (t_len != 0 && t_lin == 0)
            a = (t_base & ~(t_len - 1)) | ((t_base + n) & (t_len - 1));
        else
            a = t_base + n;
        return {1'b1, 1'b1, 8'(a & 255)};
    endfunction

    task automatic check_slot(input int s);
        logic [9:0]  e, w;
        logic        x_drive, x_wait;
        logic [15:0] x_dq;
        int          lead;
        string       tag;
        lead    = (t_early != 0) ? ((t_hold != 0) ? 2 : 1) : 0;
        e       = ref_slot(s);
        w       = ref_slot(s + lead);
        x_drive = e[8];
        x_wait  = e[9] && w[9] && !w[8];
        x_dq    = e[8] ? pat(e[7:0]) : 16'h0000;
        if (x_dq !== dq_out)      tag = (t_len != 0 && t_lin == 0) ? "R6" : "R11";
        else if (t_early != 0)    tag = "R7";
        else if (s < t_lc)        tag = "R2";
        else if (t_hold != 0)     tag = "R4";
        else if (t_len != 0)      tag = "R5";
        else                      tag = "R3";
        n_chk++;
        if (dq_drive !== x_drive || wait_o !== x_wait || dq_out !== x_dq) begin
            n_bad++;
            $display("FAIL %s lc=%0d len=%0d lin=%0d hold=%0d early=%0d base=%0d slot %0d: drive/wait/dq=%b/%b/%h expected %b/%b/%h",
                     tag, t_lc, t_len, t_lin, t_hold, t_early, t_base, s,
                     dq_drive, wait_o, dq_out, x_drive, x_wait, x_dq);
        end
    endtask

    task automatic check_quiet(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (i == 0) adv = 1'b0;
            n_chk++;
            if (dq_drive !== 1'b0 || wait_o !== 1'b0) begin
                n_bad++;
                $display("FAIL %s quiet cycle %0d: drive/wait=%b/%b expected 0/0",
                         tag, i, dq_drive, wait_o);
            end
        end
    endtask

    task automatic check_err(input string tag, input logic exp);
        n_chk++;
        if (config_error !== exp) begin
            n_bad++;
            $display("FAIL %s config_error=%b expected %b", tag, config_error, exp);
        end
    endtask

    task automatic write_cfg(input logic [9:0] v);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run_burst(input int base, input int nslots);
        t_base     = base;
        start_addr = 8'(base);
        ce         = 1'b1;
        adv        = 1'b1;
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            if (s == 0) adv = 1'b0;
            check_slot(s);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int   base;
        logic [2:0] codes [4];
        int   lens [4];
        codes = '{3'b001, 3'b010, 3'b011, 3'b111};
        lens  = '{4, 8, 16, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, page mode, no error
        n_chk++;
        if (dq_drive !== 1'b0 || wait_o !== 1'b0 || dq_out !== 16'h0) begin
            n_bad++;
            $display("FAIL R1 reset drive/wait/dq=%b/%b/%h expected 0/0/0000", dq_drive, wait_o, dq_out);
        end
        check_err("R8", 1'b0);

        // R11: load the array with a known pattern
        for (int a = 0; a < 256; a++) begin
            mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = pat(8'(a));
            @(negedge clk);
        end
        mem_we = 1'b0;

        // R1: a strobe in page mode starts nothing
        ce = 1'b1; adv = 1'b1; start_addr = 8'h10;
        check_quiet("R1", 10);

        // R8: each error cause
        write_cfg({3'b100, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0});
        check_err("R8", 1'b1);
        adv = 1'b1; check_quiet("R8", 6);
        write_cfg({3'b001, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0});
        check_err("R8", 1'b1);
        adv = 1'b1; check_quiet("R8", 6);
        write_cfg({3'b010, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0});
        check_err("R8", 1'b1);
        adv = 1'b1; check_quiet("R8", 6);
        write_cfg({3'b010, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0});
        check_err("R8", 1'b0);

        // R2 R3 R4 R5 R6 R7 R9 R11: full sweep of legal settings
        base = 245;
        for (int lc = 2; lc <= 7; lc++)
            for (int li = 0; li < 4; li++)
                for (int lin = 0; lin < 2; lin++)
                    for (int hold = 0; hold < 2; hold++)
                        for (int early = 0; early < 2; early++) begin
                            if (hold == 1 && lc == 2 && early == 1) continue;
                            t_lc = lc; t_len = lens[li]; t_lin = lin;
                            t_hold = hold; t_early = early;
                            write_cfg({codes[li], 1'(lin), 1'(early), 1'(hold), 3'(lc), 1'b0});
                            run_burst(base, lc + 36);
                            ce = 1'b0;   // R9: chip enable drop flushes
                            check_quiet("R9", 1);
                            ce = 1'b1;
                            base = (base + 37) & 255;
                        end

        // R10: restart mid-burst with a new address
        t_lc = 3; t_len = 0; t_lin = 1; t_hold = 0; t_early = 0;
        write_cfg({3'b111, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0});
        run_burst(8'h40, 12);
        run_burst(8'hC3, 24);
        ce = 1'b0;
        check_quiet("R10", 2);

        finish_run();
    end

endmodule